// File: doc/BRIEF.md
# Mid-Window Trigger Capture Controller

This block records a stream of 8-bit samples into a circular buffer of 512 entries and stops with the trigger event in the middle of the stored window. Every word it stores arrives on the sample clock. A request from the system clock domain arms a capture. The block then fills half of the buffer with history and keeps overwriting the oldest entries until the sample stream crosses a programmable level in the selected direction. After that it records enough samples to complete the window and stops.

Once the capture has finished, the system domain learns of it and streams the whole window out as bytes, oldest first. It uses a start/busy handshake to a downstream consumer. The first byte out is the sample taken 256 samples before the trigger. The last byte out is the sample taken 255 samples after it. The level and the edge direction are quasi-static inputs that may change only while no capture is in progress.

Top module: `midtrig_capture`

## Requirements
- R1: While a capture is active, the 9-bit write address steps by one, wrapping modulo 512, on every sample-clock cycle, and one registered sample is stored per cycle.
- R2: After arming, 256 samples are stored before any trigger is accepted. Level crossings that fall inside this fill are ignored.
- R3: With `trig_fall` low, a trigger is a sample that is greater than or equal to `trig_level` whose predecessor was below it. A sample exactly equal to the level counts as above it.
- R4: With `trig_fall` high, a trigger is a sample below `trig_level` whose predecessor was greater than or equal to it.
- R5: Only one trigger is taken per arm. Its write address is held, later crossings have no effect, and the capture stops after 255 further samples.
- R6: The readout emits exactly 512 bytes, starting at the held trigger address with bit 8 inverted and incrementing with wrap. The bytes are the samples from 256 before the trigger through 255 after it, in arrival order.
- R7: An arm request stays pending until the system domain sees the capture running, and then clears. Arm requests made while a capture or its readout is in progress are ignored.
- R8: Readout starts only after the capture has ended, as seen through a two-flop synchronizer. The arm request enters the sample domain through a two-flop synchronizer.
- R9: `out_start` is a one-cycle pulse, and `out_data` is valid in the same cycle. It never rises in two consecutive cycles, and it never follows a cycle in which `out_busy` was high at the clock edge. The consumer raises `out_busy` in the cycle after a pulse.
- R10: After reset, `out_start` and `out_data` are zero, and no byte appears until a capture has been armed and completed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System clock for arming and readout |
| sys_rst | input | 1 | Synchronous active-high reset, system domain |
| smp_clk | input | 1 | Sample clock |
| smp_rst | input | 1 | Synchronous active-high reset, sample domain |
| arm_req | input | 1 | One-cycle request to start a capture (system domain) |
| trig_level | input | 8 | Trigger comparison level |
| trig_fall | input | 1 | 0 selects the rising crossing, 1 the falling crossing |
| smp_in | input | 8 | Sample word, registered on `smp_clk` |
| out_busy | input | 1 | Consumer busy; blocks the next byte |
| out_start | output | 1 | One-cycle pulse marking a byte on `out_data` |
| out_data | output | 8 | Readout byte |

## Verification
The sample stream is made of low and high segments whose edge samples sit exactly on the level or one below it, so that the comparison boundary decides each trigger. One pattern places a crossing inside the pre-trigger fill and another just after the trigger. This separates a design that honours the fill and the single-trigger lock from one that re-triggers. Both edge polarities are run, together with a trigger that comes only after several overwrites of the buffer, which exercises the address wrap and the flipped-bit readout start. Consumer busy lengths of zero to three cycles and a stray arm request during a capture show whether pacing and the arm lockout hold. In every case each of the 512 bytes is compared with the sample value expected at its position.

// File: rtl/cap_pkg.sv
package cap_pkg;

  // Sample-domain capture phases
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_PRE  = 2'd1,
    PH_WAIT = 2'd2,
    PH_POST = 2'd3
  } phase_e;

endpackage

// File: rtl/cap_sync.sv
module cap_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];

endmodule

// File: rtl/cap_dpram.sv
module cap_dpram #(
  parameter int AW = 9,
  parameter int DW = 8
) (
  input  logic          wr_clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_clk,
  input  logic          rd_rst,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge wr_clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  // registered read port with output-register reset
  always_ff @(posedge rd_clk) begin
    if (rd_rst)     rd_data <= '0;
    else if (rd_en) rd_data <= mem[rd_addr];
  end

endmodule

// File: rtl/cap_acq_ctrl.sv
module cap_acq_ctrl import cap_pkg::*; #(
  parameter int AW = 9,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          arm_in,
  input  logic [DW-1:0] level,
  input  logic          fall_sel,
  input  logic [DW-1:0] din,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic [AW-1:0] trig_addr,
  output phase_e        phase
);

  localparam int            DEPTH    = 1 << AW;
  localparam int            HALF     = DEPTH / 2;
  localparam logic [AW-1:0] FILL_END = AW'(HALF - 1);

  logic [DW-1:0] smp_q;
  logic          above, above_prev, fire;
  logic [AW-1:0] cnt;

  // edge detector on the registered sample
  assign above = (smp_q >= level);
  assign fire  = fall_sel ? (~above &  above_prev)
                          : ( above & ~above_prev);

  assign wr_en   = (phase != PH_IDLE);
  assign wr_data = smp_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      smp_q      <= '0;
      above_prev <= 1'b0;
    end else begin
      smp_q      <= din;
      above_prev <= above;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= PH_IDLE;
      cnt       <= '0;
      wr_addr   <= '0;
      trig_addr <= '0;
    end else begin
      if (wr_en) wr_addr <= wr_addr + 1'b1;
      case (phase)
        PH_IDLE: begin
          if (arm_in) begin
            phase <= PH_PRE;
            cnt   <= '0;
          end
        end
        PH_PRE: begin
          cnt <= cnt + 1'b1;
          if (cnt == FILL_END) phase <= PH_WAIT;
        end
        PH_WAIT: begin
          if (fire) begin
            trig_addr <= wr_addr;
            cnt       <= cnt + 1'b1;
            phase     <= PH_POST;
          end
        end
        default: begin
          cnt <= cnt + 1'b1;
          if (&cnt) phase <= PH_IDLE;
        end
      endcase
    end
  end

endmodule

// File: rtl/cap_readout.sv
module cap_readout #(
  parameter int AW = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          arm_req,
  input  logic          cap_run,
  input  logic [AW-1:0] trig_addr,
  input  logic          out_busy,
  output logic          rd_en,
  output logic [AW-1:0] rd_addr,
  output logic          out_start,
  output logic          arm_pend
);

  localparam logic [AW-1:0] HALF_FLIP = AW'(1) << (AW - 1);

  logic          sending, run_d;
  logic [AW-1:0] send_cnt;

  // one read per free consumer slot; the pulse cycle itself is skipped
  assign rd_en = sending & ~out_busy & ~out_start;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_d     <= 1'b0;
      out_start <= 1'b0;
      arm_pend  <= 1'b0;
      sending   <= 1'b0;
      rd_addr   <= '0;
      send_cnt  <= '0;
    end else begin
      run_d     <= cap_run;
      out_start <= rd_en;

      if (arm_pend) begin
        if (cap_run) arm_pend <= 1'b0;
      end else if (arm_req && !cap_run && !run_d && !sending) begin
        arm_pend <= 1'b1;
      end

      if (!sending) begin
        if (run_d && !cap_run) begin
          sending  <= 1'b1;
          rd_addr  <= trig_addr ^ HALF_FLIP;
          send_cnt <= '0;
        end
      end else if (rd_en) begin
        rd_addr  <= rd_addr + 1'b1;
        send_cnt <= send_cnt + 1'b1;
        if (&send_cnt) sending <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/midtrig_capture.sv
module midtrig_capture import cap_pkg::*; #(
  parameter int ADDR_W      = 9,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              sys_clk,
  input  logic              sys_rst,
  input  logic              smp_clk,
  input  logic              smp_rst,
  input  logic              arm_req,
  input  logic [DATA_W-1:0] trig_level,
  input  logic              trig_fall,
  input  logic [DATA_W-1:0] smp_in,
  input  logic              out_busy,
  output logic              out_start,
  output logic [DATA_W-1:0] out_data
);

  phase_e              phase;
  logic                running_smp, running_s;
  logic                arm_pend, arm_smp;
  logic                wr_en, rd_en;
  logic [ADDR_W-1:0]   wr_addr, trig_addr, rd_addr;
  logic [DATA_W-1:0]   wr_data;

  assign running_smp = (phase != PH_IDLE);

  cap_sync #(.STAGES(SYNC_STAGES)) u_arm_sync (
    .clk (smp_clk),
    .rst (smp_rst),
    .d   (arm_pend),
    .q   (arm_smp)
  );

  cap_sync #(.STAGES(SYNC_STAGES)) u_run_sync (
    .clk (sys_clk),
    .rst (sys_rst),
    .d   (running_smp),
    .q   (running_s)
  );

  cap_acq_ctrl #(.AW(ADDR_W), .DW(DATA_W)) u_acq (
    .clk       (smp_clk),
    .rst       (smp_rst),
    .arm_in    (arm_smp),
    .level     (trig_level),
    .fall_sel  (trig_fall),
    .din       (smp_in),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .trig_addr (trig_addr),
    .phase     (phase)
  );

  cap_readout #(.AW(ADDR_W)) u_rd (
    .clk       (sys_clk),
    .rst       (sys_rst),
    .arm_req   (arm_req),
    .cap_run   (running_s),
    .trig_addr (trig_addr),
    .out_busy  (out_busy),
    .rd_en     (rd_en),
    .rd_addr   (rd_addr),
    .out_start (out_start),
    .arm_pend  (arm_pend)
  );

  cap_dpram #(.AW(ADDR_W), .DW(DATA_W)) u_buf (
    .wr_clk  (smp_clk),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_clk  (sys_clk),
    .rd_rst  (sys_rst),
    .rd_en   (rd_en),
    .rd_addr (rd_addr),
    .rd_data (out_data)
  );

endmodule

// File: rtl/midtrig_capture_chk.sv
module cap_checker import cap_pkg::*; #(
  parameter int ADDR_W = 9
) (
  input logic              sys_clk,
  input logic              sys_rst,
  input logic              smp_clk,
  input logic              smp_rst,
  input phase_e            phase,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [ADDR_W-1:0] trig_addr,
  input logic              running_s,
  input logic              arm_pend,
  input logic              out_start,
  input logic              out_busy
);

  assert_wr_step_R1: assert property (@(posedge smp_clk) disable iff (smp_rst)
    (phase != PH_IDLE) |=> (wr_addr == ADDR_W'($past(wr_addr) + 1'b1)));

  assert_no_early_post_R2: assert property (@(posedge smp_clk) disable iff (smp_rst)
    (phase == PH_PRE) |=> (phase != PH_POST));

  assert_trig_hold_R5: assert property (@(posedge smp_clk) disable iff (smp_rst)
    (phase == PH_POST) |=> $stable(trig_addr));

  assert_arm_clear_R7: assert property (@(posedge sys_clk) disable iff (sys_rst)
    running_s |=> !arm_pend);

  assert_after_capture_R8: assert property (@(posedge sys_clk) disable iff (sys_rst)
    out_start |-> !running_s);

  assert_start_gap_R9: assert property (@(posedge sys_clk) disable iff (sys_rst)
    out_start |=> !out_start);

  assert_start_busy_R9: assert property (@(posedge sys_clk) disable iff (sys_rst)
    out_start |-> $past(!out_busy));

endmodule

bind midtrig_capture cap_checker #(.ADDR_W(ADDR_W)) chk_i (
  .sys_clk   (sys_clk),
  .sys_rst   (sys_rst),
  .smp_clk   (smp_clk),
  .smp_rst   (smp_rst),
  .phase     (phase),
  .wr_addr   (wr_addr),
  .trig_addr (trig_addr),
  .running_s (running_s),
  .arm_pend  (arm_pend),
  .out_start (out_start),
  .out_busy  (out_busy)
);

// File: tb/midtrig_capture_tb.sv
`timescale 1ns/100ps
module midtrig_capture_tb_top;

  logic       sys_clk = 1'b0;
  logic       smp_clk = 1'b0;
  logic       sys_rst = 1'b1;
  logic       smp_rst = 1'b1;
  logic       arm_req = 1'b0;
  logic [7:0] trig_level = 8'h80;
  logic       trig_fall = 1'b0;
  logic [7:0] smp_in = 8'h00;
  logic       out_busy = 1'b0;
  logic       out_start;
  logic [7:0] out_data;

  always #4   sys_clk = ~sys_clk;
  always #5.5 smp_clk = ~smp_clk;

  midtrig_capture dut_i (
    .sys_clk    (sys_clk),
    .sys_rst    (sys_rst),
    .smp_clk    (smp_clk),
    .smp_rst    (smp_rst),
    .arm_req    (arm_req),
    .trig_level (trig_level),
    .trig_fall  (trig_fall),
    .smp_in     (smp_in),
    .out_busy   (out_busy),
    .out_start  (out_start),
    .out_data   (out_data)
  );

  int  n_chk = 0;
  int  n_bad = 0;
  int  k = 0;
  int  base = -100000;
  int  pat = -1;
  int  thr = 128;
  int  trel = 0;
  int  rx_n = 0;
  int  busy_len = 0;
  int  busy_cnt = 0;
  int  cyc = 0;
  bit  start_prev = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // segment map per pattern, relative to the arm time
  function automatic bit lev(input int r);
    case (pat)
      0: return (r >= 600 && r < 650) || (r >= 700 && r < 720) || (r >= 1400 && r < 1500);
      1: return (r >= 40 && r < 60) || (r >= 700 && r < 800) || (r >= 1400 && r < 1450);
      2: return (r >= 100 && r < 140) || (r >= 3000 && r < 3100);
      default: return 1'b0;
    endcase
  endfunction

  // sample value at absolute index kk; segment edges sit on the level boundary
  function automatic logic [7:0] gen(input int kk);
    int r;
    r = kk - base;
    if (lev(r)) begin
      if (!lev(r - 1)) return 8'(thr);
      return 8'(thr + ((kk * 13) % (256 - thr)));
    end
    if (lev(r - 1)) return 8'(thr - 1);
    return 8'((kk * 37) % thr);
  endfunction

  // sample source
  always @(negedge smp_clk) begin
    smp_in = gen(k);
    k = k + 1;
  end

  // consumer model and byte checks
  always @(negedge sys_clk) begin
    if (!sys_rst) begin
      if (out_start) begin
        chk(out_busy == 1'b0, "R9 start while busy", 1, 0);
        chk(start_prev == 1'b0, "R9 back-to-back start", 1, 0);
        if (rx_n == 0)
          chk(k >= base + trel + 256, "R8 readout before capture end", k, base + trel + 256);
        if (rx_n < 512)
          chk(out_data == gen(base + trel - 256 + rx_n), "R6 window byte",
              int'(out_data), int'(gen(base + trel - 256 + rx_n)));
        else
          chk(1'b0, "R7 extra byte", rx_n + 1, 512);
        rx_n = rx_n + 1;
      end
      start_prev = out_start;
      if (out_start && busy_len > 0) busy_cnt = busy_len;
      else if (busy_cnt > 0)         busy_cnt = busy_cnt - 1;
      out_busy = (busy_cnt > 0);
    end
  end

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  always @(posedge sys_clk) begin
    cyc++;
    if (cyc == 190000) begin
      n_chk++;
      n_bad++;
      $display("FAIL R6 watchdog expired actual=%0d expected=512 bytes", rx_n);
      summary();
      $finish;
    end
  end

  task automatic run(input int p, input int th, input bit fall, input int tr,
                     input int bl, input bit extra_arm, input string tag);
    pat        = p;
    thr        = th;
    trig_level = 8'(th);
    trig_fall  = fall;
    trel       = tr;
    busy_len   = bl;
    rx_n       = 0;
    @(negedge sys_clk);
    base    = k;
    arm_req = 1'b1;
    @(negedge sys_clk);
    arm_req = 1'b0;
    if (extra_arm) begin
      while (k < base + 400) @(negedge sys_clk);
      arm_req = 1'b1;
      @(negedge sys_clk);
      arm_req = 1'b0;
    end
    while (rx_n < 512) @(negedge sys_clk);
    while (k < base + tr + 1200) @(negedge sys_clk);
    repeat (300) @(negedge sys_clk);
    chk(rx_n == 512, tag, rx_n, 512);
  endtask

  initial begin
    repeat (10) @(negedge sys_clk);
    sys_rst = 1'b0;
    smp_rst = 1'b0;
    @(negedge sys_clk);
    // R10 reset state
    chk(out_start == 1'b0, "R10 out_start after reset", int'(out_start), 0);
    chk(out_data == 8'h00, "R10 out_data after reset", int'(out_data), 0);
    repeat (200) @(negedge sys_clk);
    chk(rx_n == 0, "R10 no byte before arm", rx_n, 0);

    // R3 rising at exact level, R5 crossing after latch ignored, R7 stray arm ignored
    run(0, 8'h80, 1'b0, 600, 1, 1'b1, "R7 R5 byte count rising");
    // R2 fill crossing ignored, low level, no consumer busy
    run(1, 8'h10, 1'b0, 700, 0, 1'b0, "R2 byte count fill crossing");
    // R4 falling polarity, high level, long busy
    run(1, 8'hF0, 1'b1, 800, 3, 1'b0, "R4 byte count falling");
    // R1 R6 trigger after several buffer overwrites
    run(2, 8'h80, 1'b0, 3000, 2, 1'b0, "R1 byte count long wait");

    summary();
    $finish;
  end

endmodule